// File: doc/BRIEF.md
# I2C Controller Register Block with Attention Flag

This block is the register layer between software and a byte-level I2C bus engine. Software reaches it through a simple register port with a write strobe, a read strobe and a 2-bit address. The bus engine reports each finished bus step with a one-cycle event strobe that carries a 5-bit status code. For a received byte, the strobe also carries the byte.

Each accepted event raises an attention flag. While the flag is up, the block stretches SCL low and reports the event code in the status field. It also opens the data register to software writes. Software finishes its work and then writes a one to the flag. This drops the flag and sends a one-cycle `go` pulse that lets the engine resume.

The block also does the following:
- It flags data writes made at the wrong time as write collisions.
- It drives an interrupt request.
- It holds the enable, acknowledge, START and STOP controls for the engine.
- It keeps a 2-bit clock prescaler select in the low bits of the status register.

Register map:

| Address | Register | Contents |
|---|---|---|
| 0 | control | bit 7 flag (write one to clear), bit 5 collision (read only), bit 4 STOP request, bit 3 START request, bit 2 acknowledge enable, bit 1 interrupt enable, bit 0 interface enable |
| 1 | status | bits 7..3 status, bit 2 reads 0, bits 1..0 prescaler select |
| 2 | data | data register |
| 3 | unused | reads zero |

Top module: `i2c_csr`

## Requirements
- R1: An event strobe sampled while the interface is enabled sets the attention flag (control bit 7) on that clock edge and latches the event code. Events sampled while disabled are ignored.
- R2: The flag falls only when a control write has bit 7 at one, or when the interface is disabled. A control write with bit 7 at zero leaves the flag set. A write that clears the flag makes `go` high for exactly the following cycle.
- R3: If an event strobe arrives in the same cycle as a clearing write, the flag stays set, the new code is latched and no `go` pulse is issued.
- R4: `scl_hold` is high in exactly the cycles in which the attention flag is set.
- R5: The status field (status bits 7..3) shows the latched code from one cycle after the flag is set. It shows the idle code 5'b11111 from one cycle after the flag is low. Status bit 2 always reads 0, and the status register reads 0xF8 after reset.
- R6: Status bits 1..0 hold a prescaler select that is written and read through the status register, and writes to status bits 7..2 have no effect. `presc_div` is 1, 4, 16 or 64 for a select of 00, 01, 10 or 11.
- R7: The data register resets to 0xFF. A bus write to it is accepted only while the flag is set and is otherwise ignored. A received byte that comes with an accepted event loads it and takes priority over a bus write in the same cycle. `tx_byte` shows its contents.
- R8: The write-collision bit (control bit 5) is set by a data-register write while the flag is low and cleared by a data-register write while the flag is high.
- R9: `irq` is high exactly while the flag and the interrupt enable (control bit 1) are both set.
- R10: Writing control bit 0 to zero clears the flag on that edge. While the interface is disabled, `scl_hold` and `irq` stay low.
- R11: START (bit 3), acknowledge enable (bit 2) and interface enable are changed only by control writes. The STOP request (bit 4) is also cleared by a `stop_sent` strobe, and a control write in the same cycle takes priority.
- R12: `bus_rdata` is loaded on the edge that samples `bus_rd` with the register selected by `bus_addr`, and it holds its value otherwise. Address 3 reads zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 2 | Register select |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_wdata | input | DW | Write data |
| bus_rdata | output | DW | Registered read data |
| evt_strobe | input | 1 | Bus engine finished a step |
| evt_code | input | SW | Status code of that step |
| rx_load | input | 1 | Event carries a received byte |
| rx_byte | input | DW | Received byte |
| stop_sent | input | 1 | Engine has put a STOP on the bus |
| scl_hold | output | 1 | Keep SCL stretched low |
| irq | output | 1 | Interrupt request |
| go | output | 1 | One-cycle resume pulse to the engine |
| if_enable | output | 1 | Interface enable |
| ack_en | output | 1 | Acknowledge enable |
| start_req | output | 1 | START requested |
| stop_req | output | 1 | STOP requested |
| presc_sel | output | PSW | Prescaler select |
| presc_div | output | 2*(2**PSW-1)+1 | One-hot prescaler divisor |
| tx_byte | output | DW | Data register contents |

## Verification
The bench uses the default parameters: an 8-bit data path, 5-bit status codes and a 2-bit prescaler select. With these values all four divisors, the full idle code and every control bit can be reached in a few thousand cycles of mixed random traffic. Events are dense enough that they often land in the same cycle as flag clears, data writes and disable writes. A cycle-level model written from the requirements predicts every output after every edge. Directed sequences force the following corner cases:
- an event in the same cycle as a clearing write
- a zero written to the flag
- collisions followed by a clearing data write
- a disable while the flag is set

// File: rtl/i2c_csr_pkg.sv
package i2c_csr_pkg;
  typedef enum logic [1:0] {
    A_CTRL = 2'd0,
    A_STAT = 2'd1,
    A_DATA = 2'd2,
    A_NONE = 2'd3
  } csr_addr_e;

  localparam int B_EN   = 0;
  localparam int B_IE   = 1;
  localparam int B_ACK  = 2;
  localparam int B_STA  = 3;
  localparam int B_STO  = 4;
  localparam int B_WCOL = 5;
  localparam int B_ATTN = 7;
endpackage

// File: rtl/i2c_csr_flag.sv
module i2c_csr_flag #(
  parameter int SW = 5
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          en_i,
  input  logic          set_i,
  input  logic [SW-1:0] code_i,
  input  logic          clr_i,
  output logic          attn_o,
  output logic [SW-1:0] stat_o,
  output logic          go_o
);
  localparam logic [SW-1:0] IDLE = {SW{1'b1}};

  logic          attn_q, go_q;
  logic [SW-1:0] code_q, stat_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      attn_q <= 1'b0;
      go_q   <= 1'b0;
      code_q <= IDLE;
      stat_q <= IDLE;
    end else begin
      go_q <= attn_q & clr_i & ~set_i & en_i;
      if (!en_i)      attn_q <= 1'b0;
      else if (set_i) attn_q <= 1'b1;
      else if (clr_i) attn_q <= 1'b0;
      if (set_i) code_q <= code_i;
      stat_q <= attn_q ? code_q : IDLE;
    end
  end

  assign attn_o = attn_q;
  assign stat_o = stat_q;
  assign go_o   = go_q;

  AST_FALL_NEEDS_CAUSE: assert property (@(posedge clk) disable iff (rst)
    $fell(attn_q) |-> $past(clr_i || !en_i)); // R2
  AST_GO_AFTER_CLEAR: assert property (@(posedge clk) disable iff (rst)
    go_q |-> (!attn_q && $past(attn_q))); // R2
  AST_SET_WINS: assert property (@(posedge clk) disable iff (rst)
    (set_i && en_i) |=> attn_q); // R3
  AST_IDLE_CODE: assert property (@(posedge clk) disable iff (rst)
    (!attn_q && !$past(attn_q)) |-> (stat_q == IDLE)); // R5
endmodule

// File: rtl/i2c_csr_data.sv
module i2c_csr_data #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          attn_i,
  input  logic          wr_i,
  input  logic [DW-1:0] wdata_i,
  input  logic          load_i,
  input  logic [DW-1:0] rx_i,
  output logic [DW-1:0] data_o,
  output logic          wcol_o
);
  logic [DW-1:0] data_q;
  logic          wcol_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      data_q <= {DW{1'b1}};
      wcol_q <= 1'b0;
    end else begin
      if (load_i)              data_q <= rx_i;
      else if (wr_i && attn_i) data_q <= wdata_i;
      if (wr_i) wcol_q <= ~attn_i;
    end
  end

  assign data_o = data_q;
  assign wcol_o = wcol_q;

  AST_WCOL_ON_BLOCKED: assert property (@(posedge clk) disable iff (rst)
    (wr_i && !attn_i) |=> wcol_q); // R8
  AST_DATA_FROZEN: assert property (@(posedge clk) disable iff (rst)
    (!load_i && !(wr_i && attn_i)) |=> $stable(data_q)); // R7
endmodule

// File: rtl/i2c_csr_presc.sv
module i2c_csr_presc #(
  parameter int PSW = 2
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       wr_i,
  input  logic [PSW-1:0]             sel_i,
  output logic [PSW-1:0]             sel_o,
  output logic [2*(2**PSW-1):0]      div_o
);
  localparam int DIVW = 2*(2**PSW-1)+1;

  logic [PSW-1:0] sel_q;

  always_ff @(posedge clk) begin
    if (rst)       sel_q <= '0;
    else if (wr_i) sel_q <= sel_i;
  end

  for (genvar b = 0; b < DIVW; b++) begin : g_div
    if (b % 2 == 0) begin : g_even
      assign div_o[b] = (sel_q == PSW'(b/2));
    end else begin : g_odd
      assign div_o[b] = 1'b0;
    end
  end

  assign sel_o = sel_q;

  AST_DIV_ONE_HOT: assert property (@(posedge clk) disable iff (rst)
    $countones(div_o) == 1); // R6
endmodule

// File: rtl/i2c_csr.sv
module i2c_csr
  import i2c_csr_pkg::*;
#(
  parameter int DW  = 8,
  parameter int SW  = 5,
  parameter int PSW = 2
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic [1:0]            bus_addr,
  input  logic                  bus_wr,
  input  logic                  bus_rd,
  input  logic [DW-1:0]         bus_wdata,
  output logic [DW-1:0]         bus_rdata,
  input  logic                  evt_strobe,
  input  logic [SW-1:0]         evt_code,
  input  logic                  rx_load,
  input  logic [DW-1:0]         rx_byte,
  input  logic                  stop_sent,
  output logic                  scl_hold,
  output logic                  irq,
  output logic                  go,
  output logic                  if_enable,
  output logic                  ack_en,
  output logic                  start_req,
  output logic                  stop_req,
  output logic [PSW-1:0]        presc_sel,
  output logic [2*(2**PSW-1):0] presc_div,
  output logic [DW-1:0]         tx_byte
);
  localparam int PADW = DW - SW - PSW;

  logic en_q, ie_q, ack_q, sta_q, sto_q;
  logic ctrl_wr, stat_wr, data_wr, en_next, set_evt, clr_req;
  logic attn, wcol;
  logic [SW-1:0] stat;
  logic [DW-1:0] data, rd_mux, rdata_q;

  assign ctrl_wr = bus_wr && (bus_addr == A_CTRL);
  assign stat_wr = bus_wr && (bus_addr == A_STAT);
  assign data_wr = bus_wr && (bus_addr == A_DATA);
  assign en_next = ctrl_wr ? bus_wdata[B_EN] : en_q;
  assign set_evt = evt_strobe && en_q;
  assign clr_req = ctrl_wr && bus_wdata[B_ATTN];

  always_ff @(posedge clk) begin
    if (rst) begin
      en_q  <= 1'b0;
      ie_q  <= 1'b0;
      ack_q <= 1'b0;
      sta_q <= 1'b0;
      sto_q <= 1'b0;
    end else begin
      en_q <= en_next;
      if (ctrl_wr) begin
        ie_q  <= bus_wdata[B_IE];
        ack_q <= bus_wdata[B_ACK];
        sta_q <= bus_wdata[B_STA];
        sto_q <= bus_wdata[B_STO];
      end else if (stop_sent) begin
        sto_q <= 1'b0;
      end
    end
  end

  i2c_csr_flag #(.SW(SW)) u_flag (
    .clk(clk), .rst(rst), .en_i(en_next), .set_i(set_evt), .code_i(evt_code),
    .clr_i(clr_req), .attn_o(attn), .stat_o(stat), .go_o(go)
  );

  i2c_csr_data #(.DW(DW)) u_data (
    .clk(clk), .rst(rst), .attn_i(attn), .wr_i(data_wr), .wdata_i(bus_wdata),
    .load_i(set_evt && rx_load), .rx_i(rx_byte), .data_o(data), .wcol_o(wcol)
  );

  i2c_csr_presc #(.PSW(PSW)) u_presc (
    .clk(clk), .rst(rst), .wr_i(stat_wr), .sel_i(bus_wdata[PSW-1:0]),
    .sel_o(presc_sel), .div_o(presc_div)
  );

  always_comb begin
    rd_mux = '0;
    unique case (bus_addr)
      A_CTRL: begin
        rd_mux[B_ATTN] = attn;
        rd_mux[B_WCOL] = wcol;
        rd_mux[B_STO]  = sto_q;
        rd_mux[B_STA]  = sta_q;
        rd_mux[B_ACK]  = ack_q;
        rd_mux[B_IE]   = ie_q;
        rd_mux[B_EN]   = en_q;
      end
      A_STAT:  rd_mux = {stat, {PADW{1'b0}}, presc_sel};
      A_DATA:  rd_mux = data;
      default: rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst)         rdata_q <= '0;
    else if (bus_rd) rdata_q <= rd_mux;
  end

  assign bus_rdata = rdata_q;
  assign scl_hold  = attn;
  assign irq       = attn & ie_q;
  assign if_enable = en_q;
  assign ack_en    = ack_q;
  assign start_req = sta_q;
  assign stop_req  = sto_q;
  assign tx_byte   = data;

  AST_DISABLED_QUIET: assert property (@(posedge clk) disable iff (rst)
    !en_q |-> (!scl_hold && !irq)); // R10
  AST_EVT_IGNORED_OFF: assert property (@(posedge clk) disable iff (rst)
    (!en_q && !attn) |=> !attn); // R1
  AST_RDATA_HOLDS: assert property (@(posedge clk) disable iff (rst)
    !bus_rd |=> $stable(rdata_q)); // R12
endmodule

// File: tb/i2c_csr_test.sv
`timescale 1ns/1ps
module i2c_csr_test;
  localparam int DW = 8, SW = 5, PSW = 2;

  logic clk = 1'b0, rst = 1'b1;
  logic [1:0] bus_addr = '0;
  logic bus_wr = 0, bus_rd = 0, evt_strobe = 0, rx_load = 0, stop_sent = 0;
  logic [DW-1:0] bus_wdata = '0, rx_byte = '0;
  logic [SW-1:0] evt_code = '0;
  logic [DW-1:0] bus_rdata, tx_byte;
  logic scl_hold, irq, go, if_enable, ack_en, start_req, stop_req;
  logic [PSW-1:0] presc_sel;
  logic [6:0] presc_div;

  always #4 clk = ~clk;

  i2c_csr #(.DW(DW), .SW(SW), .PSW(PSW)) uut (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .evt_strobe(evt_strobe),
    .evt_code(evt_code), .rx_load(rx_load), .rx_byte(rx_byte), .stop_sent(stop_sent),
    .scl_hold(scl_hold), .irq(irq), .go(go), .if_enable(if_enable), .ack_en(ack_en),
    .start_req(start_req), .stop_req(stop_req), .presc_sel(presc_sel),
    .presc_div(presc_div), .tx_byte(tx_byte)
  );

  int total = 0, fails = 0;
  bit done = 0;

  // reference state
  logic m_en, m_ie, m_ack, m_sta, m_sto, m_attn, m_go, m_wcol;
  logic [SW-1:0] m_code, m_stat;
  logic [DW-1:0] m_data, m_rdata;
  logic [PSW-1:0] m_presc;
  logic m_rd_seen;
  logic [1:0] m_raddr;

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s act=%0h exp=%0h t=%0t", tag, act, exp, $time);
    end
  endtask

  function automatic logic [6:0] div_of(logic [PSW-1:0] s);
    return 7'(1) << (2 * s);
  endfunction

  function automatic logic [DW-1:0] read_of(logic [1:0] a);
    case (a)
      2'd0: return {m_attn, 1'b0, m_wcol, m_sto, m_sta, m_ack, m_ie, m_en};
      2'd1: return {m_stat, 1'b0, m_presc};
      2'd2: return m_data;
      default: return '0;
    endcase
  endfunction

  task automatic model_reset();
    m_en = 0; m_ie = 0; m_ack = 0; m_sta = 0; m_sto = 0; m_attn = 0; m_go = 0;
    m_wcol = 0; m_code = '1; m_stat = '1; m_data = '1; m_rdata = '0; m_presc = '0;
    m_rd_seen = 0; m_raddr = '0;
  endtask

  task automatic idle_in();
    bus_wr = 0; bus_rd = 0; evt_strobe = 0; rx_load = 0; stop_sent = 0;
  endtask

  // one clock: predict next state from requirements, then compare ports
  task automatic step();
    logic cw, sw, dw, en_n, ev, attn_n, go_n, wcol_n, sto_n;
    logic [SW-1:0] code_n, stat_n;
    logic [DW-1:0] data_n, rdata_n;
    logic [PSW-1:0] presc_n;
    cw = bus_wr && bus_addr == 2'd0;
    sw = bus_wr && bus_addr == 2'd1;
    dw = bus_wr && bus_addr == 2'd2;
    en_n = cw ? bus_wdata[0] : m_en;
    ev = evt_strobe && m_en;
    attn_n = !en_n ? 1'b0 : ev ? 1'b1 : (cw && bus_wdata[7]) ? 1'b0 : m_attn;
    go_n = m_attn && cw && bus_wdata[7] && !ev && en_n;
    code_n = ev ? evt_code : m_code;
    stat_n = m_attn ? m_code : '1;
    data_n = (ev && rx_load) ? rx_byte : (dw && m_attn) ? bus_wdata : m_data;
    wcol_n = dw ? !m_attn : m_wcol;
    sto_n = cw ? bus_wdata[4] : (m_sto && !stop_sent);
    presc_n = sw ? bus_wdata[1:0] : m_presc;
    rdata_n = bus_rd ? read_of(bus_addr) : m_rdata;
    m_rd_seen = bus_rd; m_raddr = bus_addr;
    if (cw) begin m_ie = bus_wdata[1]; m_ack = bus_wdata[2]; m_sta = bus_wdata[3]; end
    @(posedge clk); #2;
    m_en = en_n; m_attn = attn_n; m_go = go_n; m_code = code_n; m_stat = stat_n;
    m_data = data_n; m_wcol = wcol_n; m_sto = sto_n; m_presc = presc_n; m_rdata = rdata_n;
    chk("R4 scl_hold", scl_hold, m_attn);
    chk("R9 irq", irq, m_attn & m_ie);
    chk("R2 go", go, m_go);
    chk("R10 if_enable", if_enable, m_en);
    chk("R11 ack_en", ack_en, m_ack);
    chk("R11 start_req", start_req, m_sta);
    chk("R11 stop_req", stop_req, m_sto);
    chk("R6 presc_sel", presc_sel, m_presc);
    chk("R6 presc_div", presc_div, div_of(m_presc));
    chk("R7 tx_byte", tx_byte, m_data);
    chk("R12 bus_rdata", bus_rdata, m_rdata);
    if (m_rd_seen && m_raddr == 2'd0) begin
      chk("R1 flag bit", bus_rdata[7], m_rdata[7]);
      chk("R8 collision bit", bus_rdata[5], m_rdata[5]);
    end
    if (m_rd_seen && m_raddr == 2'd1) chk("R5 status field", bus_rdata[7:2], m_rdata[7:2]);
    idle_in();
  endtask

  task automatic wr(logic [1:0] a, logic [DW-1:0] d);
    bus_wr = 1; bus_addr = a; bus_wdata = d; step();
  endtask

  task automatic rd(logic [1:0] a);
    bus_rd = 1; bus_addr = a; step();
  endtask

  task automatic event_in(logic [SW-1:0] c, logic ld, logic [DW-1:0] b);
    evt_strobe = 1; evt_code = c; rx_load = ld; rx_byte = b; step();
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      total++; fails++;
      $display("FAIL watchdog (all requirements) act=timeout exp=finish");
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5EED_0C11));
    model_reset();
    repeat (3) @(posedge clk);
    #2 rst = 0;
    // reset values
    rd(2'd1); chk("R5 reset status 0xF8", bus_rdata, 8'hF8);
    rd(2'd2); chk("R7 reset data 0xFF", bus_rdata, 8'hFF);
    // disabled: event ignored
    event_in(5'h08, 1'b0, '0); chk("R1 event ignored while disabled", scl_hold, 1'b0);
    // blocked data write sets collision
    wr(2'd2, 8'h5A); rd(2'd0); chk("R8 wcol set", bus_rdata[5], 1'b1);
    rd(2'd2); chk("R7 blocked write ignored", bus_rdata, 8'hFF);
    // enable with irq and ack
    wr(2'd0, 8'b0000_0111);
    event_in(5'h0B, 1'b1, 8'hC3);
    chk("R1 flag set", scl_hold, 1'b1); chk("R9 irq on", irq, 1'b1);
    chk("R7 rx byte loaded", tx_byte, 8'hC3);
    step(); rd(2'd1); chk("R5 code visible", bus_rdata[7:3], 5'h0B);
    wr(2'd0, 8'b0000_0111); chk("R2 zero write keeps flag", scl_hold, 1'b1);
    wr(2'd2, 8'hA5); chk("R7 write accepted", tx_byte, 8'hA5);
    rd(2'd0); chk("R8 wcol cleared", bus_rdata[5], 1'b0);
    // coincident clear and event
    evt_strobe = 1; evt_code = 5'h03; bus_wr = 1; bus_addr = 2'd0; bus_wdata = 8'h87; step();
    chk("R3 set wins", scl_hold, 1'b1); chk("R3 no go", go, 1'b0);
    wr(2'd0, 8'h87); chk("R2 cleared", scl_hold, 1'b0); chk("R2 go pulse", go, 1'b1);
    step(); chk("R2 go one cycle", go, 1'b0);
    rd(2'd1); chk("R5 idle again", bus_rdata[7:3], 5'h1F);
    // prescaler, status bits ignored
    wr(2'd1, 8'h03); chk("R6 div 64", presc_div, 7'd64);
    rd(2'd1); chk("R6 status bits unwritten", bus_rdata, 8'hFB);
    // STOP auto clear
    wr(2'd0, 8'b0001_0001); chk("R11 stop set", stop_req, 1'b1);
    stop_sent = 1; step(); chk("R11 stop cleared", stop_req, 1'b0);
    // disable while flag set
    event_in(5'h10, 1'b0, '0); wr(2'd0, 8'h00);
    chk("R10 disable clears flag", scl_hold, 1'b0);
    rd(2'd3); chk("R12 addr3 zero", bus_rdata, 8'h00);
    // random traffic
    for (int i = 0; i < 4000; i++) begin
      if ($urandom % 100 < 30) begin
        bus_wr = 1; bus_addr = 2'($urandom);
        bus_wdata = 8'($urandom);
        if (bus_addr == 2'd0) bus_wdata[0] = ($urandom % 12 != 0);
      end
      bus_rd = ($urandom % 3 == 0);
      if (!bus_wr) bus_addr = 2'($urandom);
      evt_strobe = ($urandom % 6 == 0);
      evt_code = 5'($urandom);
      rx_load = $urandom % 2; rx_byte = 8'($urandom);
      stop_sent = ($urandom % 10 == 0);
      step();
    end
    done = 1;
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule